// File: doc/BRIEF.md
# Memory Map Strobe Decoder

This block sits between an 8-bit CPU's 16-bit address bus with its three active-low strobes (program read, data read, data write) and the memories around it. From the address alone it picks one of four regions: main internal RAM at the bottom of the map, external memory in the middle, a small internal scratch RAM, and the internal peripheral and buffer space at the top. It then forms the active-low read and write enables for each internal region and passes on only those external strobes whose access does not hit internal storage. A full 64 KB external device can therefore sit on the bus with no address decoding of its own.

A mode input chooses where low code space comes from. When it is low, program reads to main RAM are served internally, so that region holds both code and data. When it is high, every program read goes to external memory and main RAM is reached only through data strobes. Program reads never enable the scratch or peripheral regions; they are passed to external memory instead. The decoder holds no state and has no clock. The address and strobe inputs are plain control pins with no handshake, so there is no back-pressure.

Top module: `memmap_strobe_decoder`

## Requirements
- R1: Every address asserts exactly one of the region selects (active high): `sel_main` for 0x0000–0x3FFF, `sel_ext` for 0x4000–0xDFFF, `sel_scratch` for 0xE000–0xE1FF and `sel_periph` for 0xE200–0xFFFF.
- R2: With `code_ext` = 0 and `sel_main` high, `main_rd_n` goes low when either `prog_rd_n` or `data_rd_n` is low. All strobes, at the inputs and at the outputs, are active low.
- R3: With `code_ext` = 1, `main_rd_n` goes low only for a data read in the main region. A program read leaves it high.
- R4: `main_wr_n` goes low exactly when `sel_main` is high and `data_wr_n` is low. At most one internal or external write enable is low at any time.
- R5: `scr_rd_n` and `scr_wr_n` follow `data_rd_n` and `data_wr_n` inside 0xE000–0xE1FF and stay high everywhere else.
- R6: `per_rd_n` and `per_wr_n` follow `data_rd_n` and `data_wr_n` inside 0xE200–0xFFFF and stay high everywhere else.
- R7: `xmem_rd_n` and `xmem_wr_n` follow the data strobes only inside 0x4000–0xDFFF. For any internal-region address they stay high.
- R8: With `code_ext` = 0, `xmem_prog_n` follows `prog_rd_n` for 0x4000–0xFFFF and stays high for 0x0000–0x3FFF. With `code_ext` = 1, it follows `prog_rd_n` at every address.
- R9: A program read to 0xE000–0xFFFF leaves `scr_rd_n` and `per_rd_n` high and appears on `xmem_prog_n`.
- R10: The outputs depend only on the current inputs. A change in any input shows at the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | CPU address bus |
| code_ext | input | 1 | 1: all code is fetched externally; 0: low code space is in main RAM |
| prog_rd_n | input | 1 | Program read strobe, active low |
| data_rd_n | input | 1 | Data read strobe, active low |
| data_wr_n | input | 1 | Data write strobe, active low |
| sel_main | output | 1 | Address lies in main internal RAM |
| sel_ext | output | 1 | Address lies in external-only space |
| sel_scratch | output | 1 | Address lies in scratch RAM |
| sel_periph | output | 1 | Address lies in peripheral/buffer space |
| main_rd_n | output | 1 | Main RAM read enable (program and data reads merged) |
| main_wr_n | output | 1 | Main RAM write enable |
| scr_rd_n | output | 1 | Scratch RAM read enable |
| scr_wr_n | output | 1 | Scratch RAM write enable |
| per_rd_n | output | 1 | Peripheral space read enable |
| per_wr_n | output | 1 | Peripheral space write enable |
| xmem_prog_n | output | 1 | Gated external program read strobe |
| xmem_rd_n | output | 1 | Gated external data read strobe |
| xmem_wr_n | output | 1 | Gated external data write strobe |

## Verification
Immediate assertions evaluate on every input change. They check that exactly one region is selected, that external data strobes stay quiet outside the external window, that write enables never overlap, that in external-code mode the program strobe passes through and main RAM ignores it, and that program reads never open the data-only regions. Only the bench scenarios show the exact region edges: 0x3FFF against 0x4000, 0xDFFF against 0xE000, and 0xE1FF against 0xE200. They also show the per-mode results for each strobe and that outputs change with no clock edge.

// File: rtl/mmdec_pkg.sv
package mmdec_pkg;

  typedef enum logic [1:0] {
    RGN_MAIN    = 2'd0,
    RGN_EXT     = 2'd1,
    RGN_SCRATCH = 2'd2,
    RGN_PERIPH  = 2'd3
  } region_e;

  localparam int unsigned NUM_REGIONS = 4;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
  } strobe_pair_t;

endpackage

// File: rtl/mmdec_region_decode.sv
module mmdec_region_decode
  import mmdec_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned MAIN_BYTES  = 16384,
  parameter int unsigned SCR_BASE    = 'hE000,
  parameter int unsigned SCR_BYTES   = 512
) (
  input  logic [ADDR_W-1:0]      addr,
  output logic [NUM_REGIONS-1:0] sel_oh
);

  localparam logic [ADDR_W-1:0] MAIN_LAST = ADDR_W'(MAIN_BYTES - 1);
  localparam logic [ADDR_W-1:0] SCR_FIRST = ADDR_W'(SCR_BASE);
  localparam logic [ADDR_W-1:0] SCR_LAST  = ADDR_W'(SCR_BASE + SCR_BYTES - 1);

  region_e region;

  always_comb begin
    if (addr <= MAIN_LAST)      region = RGN_MAIN;
    else if (addr < SCR_FIRST)  region = RGN_EXT;
    else if (addr <= SCR_LAST)  region = RGN_SCRATCH;
    else                        region = RGN_PERIPH;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sel
    assign sel_oh[g] = (region == region_e'(g));
  end

  // R1: the region compare chain covers every address once
  always_comb begin
    if (!$isunknown(addr)) begin
      a_r1_one_region: assert ($countones(sel_oh) == 1)
        else $error("region select not one-hot for %h", addr);
    end
  end

endmodule

// File: rtl/mmdec_int_enables.sv
module mmdec_int_enables
  import mmdec_pkg::*;
(
  input  logic         sel_main,
  input  logic         sel_scratch,
  input  logic         sel_periph,
  input  logic         code_ext,
  input  logic         prog_rd_n,
  input  logic         data_rd_n,
  input  logic         data_wr_n,
  output strobe_pair_t main_en,
  output strobe_pair_t scr_en,
  output strobe_pair_t per_en
);

  logic code_in_main;
  logic main_read;

  // program fetches are served internally only in internal-code mode
  assign code_in_main = ~code_ext & ~prog_rd_n;
  assign main_read    = ~data_rd_n | code_in_main;

  always_comb begin
    main_en.rd_n = ~(sel_main & main_read);
    main_en.wr_n = ~(sel_main & ~data_wr_n);
    scr_en.rd_n  = ~(sel_scratch & ~data_rd_n);
    scr_en.wr_n  = ~(sel_scratch & ~data_wr_n);
    per_en.rd_n  = ~(sel_periph & ~data_rd_n);
    per_en.wr_n  = ~(sel_periph & ~data_wr_n);
  end

  always_comb begin
    if (!$isunknown({prog_rd_n, data_rd_n, data_wr_n, code_ext,
                     sel_main, sel_scratch, sel_periph})) begin
      // R9: a lone program read never opens a data-only region
      a_r9_code_not_data: assert (!(data_rd_n && !prog_rd_n) ||
                                  (scr_en.rd_n && per_en.rd_n))
        else $error("program read enabled a data-only region");
      // R3: in external-code mode main RAM ignores program reads
      a_r3_ext_code_main: assert (!(code_ext && data_rd_n) || main_en.rd_n)
        else $error("main RAM read on program strobe in external-code mode");
    end
  end

endmodule

// File: rtl/mmdec_ext_gate.sv
module mmdec_ext_gate
  import mmdec_pkg::*;
(
  input  logic         sel_main,
  input  logic         sel_ext,
  input  logic         code_ext,
  input  logic         prog_rd_n,
  input  logic         data_rd_n,
  input  logic         data_wr_n,
  output logic         xmem_prog_n,
  output strobe_pair_t xmem_en
);

  logic data_internal;
  logic code_internal;

  assign data_internal = ~sel_ext;
  assign code_internal = sel_main & ~code_ext;

  always_comb begin
    xmem_prog_n  = prog_rd_n | code_internal;
    xmem_en.rd_n = data_rd_n | data_internal;
    xmem_en.wr_n = data_wr_n | data_internal;
  end

  always_comb begin
    if (!$isunknown({sel_main, sel_ext, code_ext, prog_rd_n,
                     data_rd_n, data_wr_n})) begin
      // R7: external data strobes stay quiet for internal addresses
      a_r7_ext_data_masked: assert (sel_ext || (xmem_en.rd_n && xmem_en.wr_n))
        else $error("external data strobe on internal address");
      // R8: external-code mode passes every program read out
      a_r8_ext_code_pass: assert (!code_ext || (xmem_prog_n == prog_rd_n))
        else $error("program strobe gated in external-code mode");
    end
  end

endmodule

// File: rtl/memmap_strobe_decoder.sv
module memmap_strobe_decoder
  import mmdec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned MAIN_BYTES = 16384,
  parameter int unsigned SCR_BASE   = 'hE000,
  parameter int unsigned SCR_BYTES  = 512
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              code_ext,
  input  logic              prog_rd_n,
  input  logic              data_rd_n,
  input  logic              data_wr_n,
  output logic              sel_main,
  output logic              sel_ext,
  output logic              sel_scratch,
  output logic              sel_periph,
  output logic              main_rd_n,
  output logic              main_wr_n,
  output logic              scr_rd_n,
  output logic              scr_wr_n,
  output logic              per_rd_n,
  output logic              per_wr_n,
  output logic              xmem_prog_n,
  output logic              xmem_rd_n,
  output logic              xmem_wr_n
);

  logic [NUM_REGIONS-1:0] sel_oh;
  strobe_pair_t           main_en, scr_en, per_en, xmem_en;

  mmdec_region_decode #(
    .ADDR_W    (ADDR_W),
    .MAIN_BYTES(MAIN_BYTES),
    .SCR_BASE  (SCR_BASE),
    .SCR_BYTES (SCR_BYTES)
  ) u_region (
    .addr  (cpu_addr),
    .sel_oh(sel_oh)
  );

  assign sel_main    = sel_oh[RGN_MAIN];
  assign sel_ext     = sel_oh[RGN_EXT];
  assign sel_scratch = sel_oh[RGN_SCRATCH];
  assign sel_periph  = sel_oh[RGN_PERIPH];

  mmdec_int_enables u_int (
    .sel_main   (sel_main),
    .sel_scratch(sel_scratch),
    .sel_periph (sel_periph),
    .code_ext   (code_ext),
    .prog_rd_n  (prog_rd_n),
    .data_rd_n  (data_rd_n),
    .data_wr_n  (data_wr_n),
    .main_en    (main_en),
    .scr_en     (scr_en),
    .per_en     (per_en)
  );

  mmdec_ext_gate u_ext (
    .sel_main   (sel_main),
    .sel_ext    (sel_ext),
    .code_ext   (code_ext),
    .prog_rd_n  (prog_rd_n),
    .data_rd_n  (data_rd_n),
    .data_wr_n  (data_wr_n),
    .xmem_prog_n(xmem_prog_n),
    .xmem_en    (xmem_en)
  );

  assign main_rd_n = main_en.rd_n;
  assign main_wr_n = main_en.wr_n;
  assign scr_rd_n  = scr_en.rd_n;
  assign scr_wr_n  = scr_en.wr_n;
  assign per_rd_n  = per_en.rd_n;
  assign per_wr_n  = per_en.wr_n;
  assign xmem_rd_n = xmem_en.rd_n;
  assign xmem_wr_n = xmem_en.wr_n;

  always_comb begin
    if (!$isunknown({cpu_addr, code_ext, prog_rd_n, data_rd_n, data_wr_n})) begin
      // R4: one write lands in exactly one place at most
      a_r4_single_write: assert ($countones({~main_wr_n, ~scr_wr_n,
                                             ~per_wr_n, ~xmem_wr_n}) <= 1)
        else $error("write enables overlap at %h", cpu_addr);
      // R7: data reads reach at most one target
      a_r7_single_data_read: assert (!prog_rd_n ||
                                     $countones({~main_rd_n, ~scr_rd_n,
                                                 ~per_rd_n, ~xmem_rd_n}) <= 1)
        else $error("data read enables overlap at %h", cpu_addr);
    end
  end

endmodule

// File: tb/memmap_strobe_decoder_test.sv
module memmap_strobe_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic        code_ext = 1'b0;
  logic        prog_rd_n = 1'b1, data_rd_n = 1'b1, data_wr_n = 1'b1;
  logic        sel_main, sel_ext, sel_scratch, sel_periph;
  logic        main_rd_n, main_wr_n, scr_rd_n, scr_wr_n, per_rd_n, per_wr_n;
  logic        xmem_prog_n, xmem_rd_n, xmem_wr_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  memmap_strobe_decoder uut (
    .cpu_addr(cpu_addr), .code_ext(code_ext),
    .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
    .sel_main(sel_main), .sel_ext(sel_ext), .sel_scratch(sel_scratch),
    .sel_periph(sel_periph), .main_rd_n(main_rd_n), .main_wr_n(main_wr_n),
    .scr_rd_n(scr_rd_n), .scr_wr_n(scr_wr_n), .per_rd_n(per_rd_n),
    .per_wr_n(per_wr_n), .xmem_prog_n(xmem_prog_n), .xmem_rd_n(xmem_rd_n),
    .xmem_wr_n(xmem_wr_n)
  );

  // outputs packed as {main,ext,scratch,periph, main_rd,main_wr,
  //   scr_rd,scr_wr,per_rd,per_wr,xprog,xrd,xwr}
  function automatic logic [12:0] observed();
    return {sel_main, sel_ext, sel_scratch, sel_periph, main_rd_n, main_wr_n,
            scr_rd_n, scr_wr_n, per_rd_n, per_wr_n, xmem_prog_n, xmem_rd_n,
            xmem_wr_n};
  endfunction

  // entry: {req[3:0], addr[15:0], code_ext, prog,data_rd,data_wr, sel[3:0], strobes[8:0]}
  localparam logic [36:0] VEC [16] = '{
    {4'd2,  16'h0000, 1'b0, 3'b011, 4'b1000, 9'b011111111}, // R2 code read
    {4'd2,  16'h3FFF, 1'b0, 3'b101, 4'b1000, 9'b011111111}, // R2 data read
    {4'd3,  16'h3FFF, 1'b1, 3'b011, 4'b1000, 9'b111111011}, // R3 code goes out
    {4'd3,  16'h0100, 1'b1, 3'b101, 4'b1000, 9'b011111111}, // R3 data stays in
    {4'd4,  16'h2000, 1'b0, 3'b110, 4'b1000, 9'b101111111}, // R4 write
    {4'd7,  16'h4000, 1'b0, 3'b101, 4'b0100, 9'b111111101}, // R7 ext read
    {4'd7,  16'hDFFF, 1'b0, 3'b110, 4'b0100, 9'b111111110}, // R7 ext write
    {4'd8,  16'h4000, 1'b0, 3'b011, 4'b0100, 9'b111111011}, // R8 ext code
    {4'd5,  16'hE000, 1'b0, 3'b101, 4'b0010, 9'b110111111}, // R5 scratch rd
    {4'd5,  16'hE1FF, 1'b1, 3'b110, 4'b0010, 9'b111011111}, // R5 scratch wr
    {4'd6,  16'hE200, 1'b0, 3'b101, 4'b0001, 9'b111101111}, // R6 periph rd
    {4'd6,  16'hFFFF, 1'b0, 3'b110, 4'b0001, 9'b111110111}, // R6 periph wr
    {4'd9,  16'hE100, 1'b0, 3'b011, 4'b0010, 9'b111111011}, // R9 code to scratch
    {4'd9,  16'hF000, 1'b1, 3'b011, 4'b0001, 9'b111111011}, // R9 code to periph
    {4'd1,  16'hE1FF, 1'b0, 3'b111, 4'b0010, 9'b111111111}, // R1 idle edge
    {4'd1,  16'h0000, 1'b1, 3'b111, 4'b1000, 9'b111111111}  // R1 idle bottom
  };

  task automatic check(input string req, input logic [12:0] exp);
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s addr=%h mode=%b actual=%b expected=%b",
               req, cpu_addr, code_ext, observed(), exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic m, input logic [2:0] s);
    @(negedge clk);
    cpu_addr = a;
    code_ext = m;
    {prog_rd_n, data_rd_n, data_wr_n} = s;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // idle state after bench reset: only a region select, all strobes high (R1)
    apply(16'h0000, 1'b0, 3'b111);
    check("R1", {4'b1000, 9'b111111111});

    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][32:17], VEC[i][16], VEC[i][15:13]);
      check($sformatf("R%0d", VEC[i][36:33]), VEC[i][12:0]);
    end

    // R1 boundaries around the external window
    apply(16'h3FFF, 1'b0, 3'b111);  check("R1", {4'b1000, 9'b111111111});
    apply(16'h4000, 1'b0, 3'b111);  check("R1", {4'b0100, 9'b111111111});
    apply(16'hDFFF, 1'b0, 3'b111);  check("R1", {4'b0100, 9'b111111111});
    apply(16'hE200, 1'b1, 3'b111);  check("R1", {4'b0001, 9'b111111111});

    // R8: internal-code mode blocks external fetch in main space
    apply(16'h1234, 1'b0, 3'b011);  check("R8", {4'b1000, 9'b011111111});
    // R8: external-code mode at ext address
    apply(16'h8000, 1'b1, 3'b011);  check("R8", {4'b0100, 9'b111111011});
    // R7: data write to main stays off the external bus
    apply(16'h0000, 1'b1, 3'b110);  check("R7", {4'b1000, 9'b101111111});
    // R2: program and data read together in main space
    apply(16'h0010, 1'b0, 3'b001);  check("R2", {4'b1000, 9'b011111111});

    // R10: change inputs between edges, result visible without a clock
    @(posedge clk);
    #2;
    cpu_addr = 16'hE050;
    {prog_rd_n, data_rd_n, data_wr_n} = 3'b101;
    code_ext = 1'b0;
    #1;
    check("R10", {4'b0010, 9'b110111111});
    data_rd_n = 1'b1;
    #1;
    check("R10", {4'b0010, 9'b111111111});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule